// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block holds the eight-bit status register of a serial flash model and the rules that decide when it may change. A command decoder in front of it sends one strobe per finished instruction, with a small operation code. The internal write engine sends start and completion events. The block tracks the busy flag, the write-enable latch, the auto-increment programming flag, four block-protect bits and the lock bit. It applies the write-enable, write-disable, status-write arming and status-write rules. It also applies the lock-down that the write-protect pin (active low) controls.

The block also turns the block-protect code into a protected region at the top of the array. Every cycle it checks one target range against that region. The target is a single byte, a 4 KB sector, a 32 KB block or a 64 KB block, and the low address bits inside the unit are ignored. The program and erase sequencer uses the registered flag to veto the request. A separate flag reports whether a chip erase may run.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte is 0x1C: block-protect bits [4:2] = 1, and bit 5, the lock bit (bit 7), the auto-increment flag (bit 6), the write-enable latch (bit 1) and the busy flag (bit 0) are 0. `prot_hit` is 0.
- R2: Operation codes on `cmd_op` are: 0 any other instruction, 1 write-enable, 2 write-disable, 3 arm status write, 4 status write. A strobe with code 1 sets bit 1. Code 2 clears bit 1 and bit 6.
- R3: A status write (code 4) takes effect only if the strobe just before it carried code 1 or code 3. Any strobe with another code in between removes the arm.
- R4: An accepted status write copies `wrsr_data[5:2]` into status bits [5:2] and `wrsr_data[7]` into bit 7. Data bits 6, 1 and 0 have no effect.
- R5: With `wp_n` low and the lock bit set, a status write is ignored. While `wp_n` is low, the lock bit never falls. With `wp_n` high, the lock bit does not block a write.
- R6: Every status-write strobe clears the write-enable latch, whether the write is accepted or not.
- R7: `busy_start` sets bit 0. `busy_done` clears bit 0, and also clears bit 1 unless bit 6 is set.
- R8: `aai_start` sets bit 6. `aai_stop` clears bit 6 and bit 1.
- R9: A write-enable strobe in the same cycle as `busy_done` or `aai_stop` leaves bit 1 set.
- R10: Protection code = status bits [4:2] (bit 5 ignored). With 2 MB of address space: 0 protects nothing; codes 1 to 5 protect the top 1/32, 1/16, 1/8, 1/4 and 1/2 (from 0x1F0000, 0x1E0000, 0x1C0000, 0x180000, 0x100000); 6 and 7 protect everything.
- R11: `chk_span` 0 byte, 1 4 KB, 2 32 KB, 3 64 KB. The target unit is aligned by ignoring its low address bits. `prot_hit` is 1, one cycle after the inputs, when any byte of the unit lies in the protected region.
- R12: `chip_erase_ok` is 1 exactly when status bits [5:2] are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | One-cycle strobe for a finished instruction |
| cmd_op | input | 3 | Operation code of the strobed instruction |
| wrsr_data | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy_start | input | 1 | Internal write operation begins |
| busy_done | input | 1 | Internal write operation completes |
| aai_start | input | 1 | Auto-increment programming mode entered |
| aai_stop | input | 1 | Auto-increment programming mode ended |
| chk_addr | input | ADDR_W | Address of the target under check |
| chk_span | input | 2 | Size of the target unit |
| status | output | 8 | Status byte |
| prot_hit | output | 1 | Target overlaps the protected region (registered) |
| chip_erase_ok | output | 1 | Chip erase permitted |

## Verification
Two events can land on the write-enable latch in the same cycle: a write-enable strobe and a completion event (`busy_done` or `aai_stop`) from the engine. Directed steps drive both in one clock. The latch must read 1 afterwards, and the busy or auto-increment flag must still fall. The random phase also mixes strobes with engine events and compares every status bit against an independent model after each edge. The range check and a status write can also share a cycle. The bench expects `prot_hit` to reflect the protection code from before that write.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_ARM   = 3'd3,
    OP_WRSR  = 3'd4
  } sr_op_e;

  typedef enum logic [1:0] {
    SPAN_BYTE = 2'd0,
    SPAN_SECT = 2'd1,
    SPAN_B32  = 2'd2,
    SPAN_B64  = 2'd3
  } span_e;

  localparam int BP_W = 4;
endpackage

// File: rtl/sr_latch_ctrl.sv
module sr_latch_ctrl
  import sr_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_stb,
  input  sr_op_e cmd_op,
  input  logic   busy_start,
  input  logic   busy_done,
  input  logic   aai_start,
  input  logic   aai_stop,
  output logic   wel,
  output logic   aai,
  output logic   busy,
  output logic   armed
);
  logic is_wren, is_wrdi, is_wrsr;
  logic wel_drop;

  always_comb begin
    is_wren  = cmd_stb && (cmd_op == OP_WREN);
    is_wrdi  = cmd_stb && (cmd_op == OP_WRDI);
    is_wrsr  = cmd_stb && (cmd_op == OP_WRSR);
    wel_drop = is_wrdi || is_wrsr || aai_stop || (busy_done && !aai);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel   <= 1'b0;
      aai   <= 1'b0;
      busy  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (cmd_stb)
        armed <= (cmd_op == OP_WREN) || (cmd_op == OP_ARM);
      if (busy_start)     busy <= 1'b1;
      else if (busy_done) busy <= 1'b0;
      if (is_wrdi || aai_stop) aai <= 1'b0;
      else if (aai_start)      aai <= 1'b1;
      if (is_wren)       wel <= 1'b1;
      else if (wel_drop) wel <= 1'b0;
    end
  end

  // R2
  wrdi_clears_chk: assert property (@(posedge clk) disable iff (rst)
    is_wrdi |=> (!wel && !aai));
  // R6
  wrsr_drops_wel_chk: assert property (@(posedge clk) disable iff (rst)
    is_wrsr |=> !wel);
  // R9
  wren_wins_chk: assert property (@(posedge clk) disable iff (rst)
    is_wren |=> wel);
  // R7
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    busy_start |=> busy);
endmodule

// File: rtl/sr_prot_bits.sv
module sr_prot_bits
  import sr_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_stb,
  input  sr_op_e          cmd_op,
  input  logic [7:0]      wrsr_data,
  input  logic            wp_n,
  input  logic            armed,
  output logic [BP_W-1:0] bp,
  output logic            bpl
);
  localparam logic [BP_W-1:0] BP_RESET = {1'b0, {(BP_W-1){1'b1}}};

  logic is_wrsr, locked, accept;

  always_comb begin
    is_wrsr = cmd_stb && (cmd_op == OP_WRSR);
    locked  = !wp_n && bpl;
    accept  = is_wrsr && armed && !locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp  <= BP_RESET;
      bpl <= 1'b0;
    end else if (accept) begin
      bp  <= wrsr_data[2 +: BP_W];
      bpl <= wrsr_data[7];
    end
  end

  // R5
  locked_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (is_wrsr && !wp_n && bpl) |=> ($stable(bp) && $stable(bpl)));
  // R5
  lock_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && bpl) |=> bpl);
  // R3
  unarmed_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (is_wrsr && !armed) |=> ($stable(bp) && $stable(bpl)));
endmodule

// File: rtl/sr_range_chk.sv
module sr_range_chk
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int SECT_W  = 12,
  parameter int BLKS_W  = 15,
  parameter int BLKL_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bp_code,
  input  logic [ADDR_W-1:0] chk_addr,
  input  span_e             chk_span,
  output logic              prot_hit
);
  localparam logic [ADDR_W-1:0] ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] M_SECT = ONES >> (ADDR_W - SECT_W);
  localparam logic [ADDR_W-1:0] M_BLKS = ONES >> (ADDR_W - BLKS_W);
  localparam logic [ADDR_W-1:0] M_BLKL = ONES >> (ADDR_W - BLKL_W);

  logic [ADDR_W-1:0] low_mask, last_addr, top_mask;
  logic [2:0]        frac_k;
  logic              hit_d;

  always_comb begin
    unique case (chk_span)
      SPAN_SECT: low_mask = M_SECT;
      SPAN_B32:  low_mask = M_BLKS;
      SPAN_B64:  low_mask = M_BLKL;
      default:   low_mask = '0;
    endcase
    last_addr = chk_addr | low_mask;
    frac_k    = 3'd6 - bp_code;
    top_mask  = ~(ONES >> frac_k);
    if (bp_code == 3'd0)        hit_d = 1'b0;
    else if (bp_code >= 3'd6)   hit_d = 1'b1;
    else                        hit_d = ((last_addr & top_mask) == top_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) prot_hit <= 1'b0;
    else     prot_hit <= hit_d;
  end

  // R10
  none_protected_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_code == 3'd0) |=> !prot_hit);
  // R10
  all_protected_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_code[2:1] == 2'b11) |=> prot_hit);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import sr_guard_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 12,
  parameter int BLKS_W = 15,
  parameter int BLKL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  input  logic              busy_start,
  input  logic              busy_done,
  input  logic              aai_start,
  input  logic              aai_stop,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_span,
  output logic [7:0]        status,
  output logic              prot_hit,
  output logic              chip_erase_ok
);
  sr_op_e          op;
  logic            wel, aai, busy, armed, bpl;
  logic [BP_W-1:0] bp;

  assign op = sr_op_e'(cmd_op);

  sr_latch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(op),
    .busy_start(busy_start), .busy_done(busy_done),
    .aai_start(aai_start), .aai_stop(aai_stop),
    .wel(wel), .aai(aai), .busy(busy), .armed(armed)
  );

  sr_prot_bits u_bits (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(op),
    .wrsr_data(wrsr_data), .wp_n(wp_n), .armed(armed),
    .bp(bp), .bpl(bpl)
  );

  sr_range_chk #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLKS_W(BLKS_W), .BLKL_W(BLKL_W)
  ) u_range (
    .clk(clk), .rst(rst), .bp_code(bp[2:0]), .chk_addr(chk_addr),
    .chk_span(span_e'(chk_span)), .prot_hit(prot_hit)
  );

  assign status        = {bpl, aai, bp, wel, busy};
  assign chip_erase_ok = (bp == '0);

  // R12
  erase_gate_chk: assert property (@(posedge clk) disable iff (rst)
    chip_erase_ok |-> (status[5:2] == 4'd0));
endmodule

// File: tb/flash_sr_guard_bench.sv
`timescale 1ns/1ps
module flash_sr_guard_bench;
  localparam int AW = 21;
  localparam logic [2:0] C_OTH = 3'd0, C_WREN = 3'd1, C_WRDI = 3'd2,
                         C_ARM = 3'd3, C_WRSR = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_stb = 0; logic [2:0] cmd_op = 0; logic [7:0] wrsr_data = 0;
  logic wp_n = 1; logic busy_start = 0, busy_done = 0, aai_start = 0, aai_stop = 0;
  logic [AW-1:0] chk_addr = 0; logic [1:0] chk_span = 0;
  logic [7:0] status; logic prot_hit, chip_erase_ok;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_sr_guard u_flash_sr_guard (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .wrsr_data(wrsr_data), .wp_n(wp_n), .busy_start(busy_start),
    .busy_done(busy_done), .aai_start(aai_start), .aai_stop(aai_stop),
    .chk_addr(chk_addr), .chk_span(chk_span), .status(status),
    .prot_hit(prot_hit), .chip_erase_ok(chip_erase_ok)
  );

  // reference model state
  logic m_wel, m_aai, m_busy, m_arm, m_bpl, m_prot;
  logic [3:0] m_bp;

  function automatic logic exp_prot(input logic [3:0] bp, input logic [AW-1:0] a,
                                    input logic [1:0] sp);
    longint size, unit, last, bound;
    int c;
    size = longint'(1) << AW;
    unit = (sp == 0) ? 1 : (sp == 1) ? 4096 : (sp == 2) ? 32768 : 65536;
    last = (longint'(a) / unit) * unit + unit - 1;
    c = int'(bp[2:0]);
    if (c == 0) return 1'b0;
    if (c >= 6) return 1'b1;
    bound = size - (size >> (6 - c));
    return last >= bound;
  endfunction

  function automatic logic [7:0] m_status();
    return {m_bpl, m_aai, m_bp, m_wel, m_busy};
  endfunction

  task automatic check(input string tag);
    n_tests++;
    if (status !== m_status()) begin
      n_fail++;
      $display("FAIL %s status got %h exp %h", tag, status, m_status());
    end
    n_tests++;
    if (prot_hit !== m_prot) begin
      n_fail++;
      $display("FAIL %s prot_hit got %b exp %b", tag, prot_hit, m_prot);
    end
    n_tests++;
    if (chip_erase_ok !== (m_bp == 4'd0)) begin
      n_fail++;
      $display("FAIL %s chip_erase_ok got %b exp %b", tag, chip_erase_ok, (m_bp == 4'd0));
    end
  endtask

  task automatic step(input string tag);
    logic accept, wren, wrdi, wrsr;
    @(posedge clk);
    m_prot = exp_prot(m_bp, chk_addr, chk_span);
    wren = cmd_stb && cmd_op == C_WREN;
    wrdi = cmd_stb && cmd_op == C_WRDI;
    wrsr = cmd_stb && cmd_op == C_WRSR;
    accept = wrsr && m_arm && (wp_n || !m_bpl);
    if (wren) m_wel = 1;
    else if (wrdi || wrsr || aai_stop || (busy_done && !m_aai)) m_wel = 0;
    if (wrdi || aai_stop) m_aai = 0; else if (aai_start) m_aai = 1;
    if (busy_start) m_busy = 1; else if (busy_done) m_busy = 0;
    if (accept) begin m_bp = wrsr_data[5:2]; m_bpl = wrsr_data[7]; end
    if (cmd_stb) m_arm = (cmd_op == C_WREN) || (cmd_op == C_ARM);
    @(negedge clk);
    check(tag);
    cmd_stb = 0; busy_start = 0; busy_done = 0; aai_start = 0; aai_stop = 0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] d, input string tag);
    cmd_stb = 1; cmd_op = op; wrsr_data = d;
    step(tag);
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic [1:0] sp, input string tag);
    chk_addr = a; chk_span = sp;
    step(tag);
  endtask

  task automatic set_bp(input logic [7:0] d);
    wp_n = 1;
    cmd(C_ARM, 0, "R4");
    cmd(C_WRSR, d, "R4");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_wel = 0; m_aai = 0; m_busy = 0; m_arm = 0; m_bpl = 0; m_prot = 0; m_bp = 4'b0111;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset");
    cmd(C_WREN, 0, "R2 wren");
    cmd(C_WRDI, 0, "R2 wrdi");
    cmd(C_OTH, 0, "R3 other");
    cmd(C_WRSR, 8'h00, "R3 unarmed");
    cmd(C_ARM, 0, "R3 arm");
    cmd(C_OTH, 0, "R3 disarm");
    cmd(C_WRSR, 8'h00, "R3 stale arm");
    cmd(C_ARM, 0, "R4 arm");
    cmd(C_WRSR, 8'h43, "R4 ignored bits R12");
    wp_n = 0;
    cmd(C_WREN, 0, "R5 wren");
    cmd(C_WRSR, 8'h84, "R5 lock set R6");
    cmd(C_ARM, 0, "R5 arm");
    cmd(C_WRSR, 8'h00, "R5 locked");
    cmd(C_WREN, 0, "R6 wren");
    cmd(C_WRSR, 8'h00, "R6 rejected clears wel");
    wp_n = 1;
    cmd(C_ARM, 0, "R5 arm");
    cmd(C_WRSR, 8'h00, "R5 pin high");
    cmd(C_WREN, 0, "R7 wren");
    busy_start = 1; step("R7 busy set");
    busy_done = 1; step("R7 done clears wel");
    cmd(C_WREN, 0, "R8 wren");
    aai_start = 1; busy_start = 1; step("R8 aai set");
    busy_done = 1; step("R7 done in aai keeps wel");
    aai_stop = 1; step("R8 aai stop");
    cmd(C_WREN, 0, "R2 wren");
    aai_start = 1; step("R2 aai");
    cmd(C_WRDI, 0, "R2 wrdi clears aai");
    busy_start = 1; step("R9 busy");
    busy_done = 1; cmd(C_WREN, 0, "R9 wren with done");
    aai_start = 1; step("R9 aai");
    aai_stop = 1; cmd(C_WREN, 0, "R9 wren with aai stop");
    set_bp(8'h04);
    probe(21'h1EFFFF, 0, "R10 below 1/32");
    probe(21'h1F0000, 0, "R10 at 1/32");
    probe(21'h1EF123, 1, "R11 sector below");
    probe(21'h1E8000, 3, "R11 64K below");
    probe(21'h1F7FFF, 2, "R11 32K inside");
    set_bp(8'h14);
    probe(21'h0FFFFF, 0, "R10 below half");
    probe(21'h0F0000, 3, "R11 64K below half");
    probe(21'h100000, 0, "R10 at half");
    probe(21'h0FF000, 2, "R11 32K below half");
    set_bp(8'h18);
    probe(21'h000000, 0, "R10 all");
    set_bp(8'h00);
    probe(21'h1FFFFF, 1, "R10 none");
    set_bp(8'h20);
    probe(21'h1FFFFF, 0, "R10 bp3 ignored R12");
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 6);
      wp_n = ($urandom % 4) != 0;
      cmd_stb = ($urandom % 3) != 0;
      cmd_op = 3'($urandom % 5);
      wrsr_data = 8'($urandom);
      chk_addr = AW'($urandom);
      chk_span = 2'($urandom);
      busy_start = (r == 1); busy_done = (r == 2);
      aai_start = (r == 3); aai_stop = (r == 4);
      step("RND");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule